// File: doc/BRIEF.md
# Fixed-Point to Compact Float Encoder

This block turns a signed fixed-point number into a 32-bit floating-point word that has a very narrow exponent. The input is a 32-bit two's-complement value with 16 integer bits and 16 fraction bits. The output word holds three fields: a sign, a 4-bit exponent stored with an offset of 7, and a 27-bit fraction with an implied leading one. Because the exponent field is so small, every conversion is checked against the range it can represent. Values that are too large saturate and raise an overflow flag. Values that are too small flush to zero and raise an underflow flag. An exact zero input raises its own zero flag.

Input and output each use a valid/ready handshake. One registered stage sits between them. Inside the block, the datapath takes the magnitude, finds the leading one, shifts the value into normalised position, offsets the exponent and packs the fields. Bits that do not fit are dropped (truncation), with no rounding.

Top module: `fxf_encoder`

## Requirements
- R1: The output word places the sign at bit 31, the stored exponent at bits 30:27 and the fraction at bits 26:0. The sign bit is 1 exactly when a nonzero, in-range or overflowing input is negative.
- R2: For an in-range input, the stored exponent equals p − 16 + 7. Here p is the bit index of the leading one of the input magnitude.
- R3: The fraction field holds the magnitude bits below the leading one, left-aligned so the bit just below the leading one lands at bit 26. Bits below the field are discarded, and the leading one itself is not stored.
- R4: A negative input is converted through its two's-complement magnitude. The most negative input, 0x80000000, is treated as magnitude 2^31 and does not wrap.
- R5: A zero input produces the word 0x00000000 with the zero flag set and the other two flags clear.
- R6: When p − 16 > 8, the output keeps the sign and sets the exponent to 15 and the fraction to all ones. It raises the overflow flag and clears the other flags.
- R7: When p − 16 < −7, the output word is 0x00000000. It raises the underflow flag, and the zero and overflow flags are clear.
- R8: The input 0x00592000 (89.125) encodes as 0x6B240000.
- R9: After reset, out_valid is 0 and in_ready is 1. The output becomes valid on the clock edge that accepts an input, so it is visible in the cycle after the acceptance.
- R10: While out_valid is 1 and out_ready is 0, the output word and flags hold steady and in_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample is offered |
| in_ready | output | 1 | Stage can take a sample this cycle |
| in_data | input | 32 | Signed fixed-point input, 16.16 two's complement |
| out_valid | output | 1 | Encoded result is available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_word | output | 32 | Encoded float word |
| out_ovf | output | 1 | Result saturated on overflow |
| out_unf | output | 1 | Result flushed on underflow |
| out_zero | output | 1 | Input was exactly zero |

## Verification
Several properties are checked on every cycle:
- the handshake: the output becomes valid after an acceptance, holds under backpressure, and in_ready drops while the stage is stalled;
- the flags are mutually exclusive;
- the word forced by each flag is the right one;
- after any nonzero input, the leading-one detector points at the true top bit of the magnitude.

Some things only the bench's sweeps can show. These are the exact exponent and fraction values, the two range boundaries (leading-one positions 8/9 and 24/25), the handling of negative magnitudes including the most negative input, and the 89.125 vector. The sweeps cover every leading-one position for both signs.

// File: rtl/fxf_pkg.sv
package fxf_pkg;

   // Condition flags that travel with each encoded word
   typedef struct packed {
      logic ovf;
      logic unf;
      logic zero;
   } fxf_flags_t;

   localparam int FLAGS_W = $bits(fxf_flags_t);

endpackage

// File: rtl/fxf_magnitude.sv
module fxf_magnitude #(
   parameter int IN_W = 32
) (
   input  logic [IN_W-1:0] value,
   output logic            negative,
   output logic [IN_W-1:0] mag
);
   // Unsigned magnitude: the most negative code maps to 2^(IN_W-1),
   // which still fits in IN_W unsigned bits
   assign negative = value[IN_W-1];
   assign mag      = negative ? (~value + IN_W'(1)) : value;
endmodule

// File: rtl/fxf_lead_one.sv
module fxf_lead_one #(
   parameter int IN_W  = 32,
   parameter int POS_W = $clog2(IN_W)
) (
   input  logic [IN_W-1:0]  mag,
   output logic             any,
   output logic [POS_W-1:0] pos
);
   // Higher bits overwrite lower ones, so the highest set bit wins
   always_comb begin
      pos = '0;
      for (int i = 0; i < IN_W; i++) begin
         if (mag[i]) pos = POS_W'(i);
      end
   end

   assign any = |mag;
endmodule

// File: rtl/fxf_pack.sv
module fxf_pack
   import fxf_pkg::*;
#(
   parameter int IN_W    = 32,
   parameter int FRAC_IN = 16,
   parameter int EXP_W   = 4,
   parameter int BIAS    = 7,
   parameter int MAN_W   = 27,
   parameter int POS_W   = $clog2(IN_W),
   parameter int WORD_W  = 1 + EXP_W + MAN_W
) (
   input  logic [IN_W-1:0]   mag,
   input  logic              negative,
   input  logic              any,
   input  logic [POS_W-1:0]  pos,
   output logic [WORD_W-1:0] word,
   output fxf_flags_t        flags
);
   localparam int EXP_MAX = (1 << EXP_W) - 1;

   logic [IN_W-1:0]  shifted;
   logic [MAN_W-1:0] frac;

   // Move the leading one up to the top bit of the input width
   assign shifted = mag << (IN_W - 1 - int'(pos));

   // Keep only the bits below the leading one. The variant depends on
   // whether the fraction field is narrower than those bits.
   generate
      if (MAN_W <= IN_W - 1) begin : g_trunc
         assign frac = MAN_W'(shifted >> (IN_W - 1 - MAN_W));
      end else begin : g_pad
         assign frac = MAN_W'(shifted) << (MAN_W - IN_W + 1);
      end
   endgenerate

   always_comb begin
      int e;
      e     = int'(pos) - FRAC_IN + BIAS;
      word  = '0;
      flags = '0;
      if (!any) begin
         flags.zero = 1'b1;
      end else if (e > EXP_MAX) begin
         word      = {negative, {EXP_W{1'b1}}, {MAN_W{1'b1}}};
         flags.ovf = 1'b1;
      end else if (e < 0) begin
         flags.unf = 1'b1;
      end else begin
         word = {negative, EXP_W'(e), frac};
      end
   end

   // The detector's position must be the top set bit of the magnitude
   always_comb begin
      if (any) begin
         AST_LEAD_POSITION: assert ((mag >> pos) == IN_W'(1)); // R3
      end
   end
endmodule

// File: rtl/fxf_stage.sv
module fxf_stage #(
   parameter int W = 35
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);
   assign in_ready = !out_valid || out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (in_valid && in_ready) begin
         out_valid <= 1'b1;
         out_data  <= in_data;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid); // R9
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data)); // R10
   AST_NO_ACCEPT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready); // R10
endmodule

// File: rtl/fxf_encoder.sv
module fxf_encoder
   import fxf_pkg::*;
#(
   parameter int IN_W    = 32,
   parameter int FRAC_IN = 16,
   parameter int EXP_W   = 4,
   parameter int BIAS    = 7,
   parameter int MAN_W   = 27,
   parameter int WORD_W  = 1 + EXP_W + MAN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [IN_W-1:0]   in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_word,
   output logic              out_ovf,
   output logic              out_unf,
   output logic              out_zero
);
   localparam int POS_W  = $clog2(IN_W);
   localparam int STG_W  = WORD_W + FLAGS_W;
   localparam int EXP_MX = (1 << EXP_W) - 1;

   // Elaboration-time parameter checks
   generate
      if (IN_W < 2 || FRAC_IN >= IN_W) begin : g_bad_in
         $error("fxf_encoder: input width must exceed fraction width");
      end
      if (EXP_W < 2) begin : g_bad_exp
         $error("fxf_encoder: exponent field too narrow");
      end
      if (BIAS < 0 || BIAS > EXP_MX) begin : g_bad_bias
         $error("fxf_encoder: bias outside exponent field range");
      end
      if (MAN_W < 1) begin : g_bad_man
         $error("fxf_encoder: fraction field must be nonempty");
      end
   endgenerate

   logic              negative;
   logic [IN_W-1:0]   mag;
   logic              any;
   logic [POS_W-1:0]  pos;
   logic [WORD_W-1:0] word_c;
   fxf_flags_t        flags_c;
   fxf_flags_t        flags_q;
   logic [STG_W-1:0]  stage_q;

   fxf_magnitude #(.IN_W(IN_W)) i_magnitude (
      .value    (in_data),
      .negative (negative),
      .mag      (mag)
   );

   fxf_lead_one #(.IN_W(IN_W), .POS_W(POS_W)) i_lead_one (
      .mag (mag),
      .any (any),
      .pos (pos)
   );

   fxf_pack #(
      .IN_W(IN_W), .FRAC_IN(FRAC_IN), .EXP_W(EXP_W), .BIAS(BIAS),
      .MAN_W(MAN_W), .POS_W(POS_W), .WORD_W(WORD_W)
   ) i_pack (
      .mag      (mag),
      .negative (negative),
      .any      (any),
      .pos      (pos),
      .word     (word_c),
      .flags    (flags_c)
   );

   fxf_stage #(.W(STG_W)) i_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   ({flags_c, word_c}),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (stage_q)
   );

   assign {flags_q, out_word} = stage_q;
   assign out_ovf  = flags_q.ovf;
   assign out_unf  = flags_q.unf;
   assign out_zero = flags_q.zero;

   AST_FLAG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $onehot0({out_ovf, out_unf, out_zero})); // R5
   AST_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_zero |-> out_word == '0); // R5
   AST_SAT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ovf |-> &out_word[WORD_W-2:0]); // R6
   AST_UNF_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_unf |-> out_word == '0); // R7
endmodule

// File: tb/test_fxf_encoder.sv
module test_fxf_encoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_data = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] out_word;
   logic        out_ovf, out_unf, out_zero;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   fxf_encoder i_fxf_encoder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_word(out_word), .out_ovf(out_ovf), .out_unf(out_unf),
      .out_zero(out_zero)
   );

   // Arithmetic reference model built from the requirements
   task automatic ref_model(input logic [31:0] x, output logic [34:0] exp_v);
      longint m, r, frac;
      int k;
      logic s;
      s = x[31];
      m = s ? -longint'($signed(x)) : longint'(x);
      if (m == 0) begin
         exp_v = {3'b001, 32'h0};                              // R5
         return;
      end
      k = 0;
      for (int i = 0; i < 40; i++) if (m >= (64'sd1 <<< i)) k = i;
      if (k - 16 > 8) begin
         exp_v = {3'b100, s, 4'hF, 27'h7FF_FFFF};              // R6
      end else if (k - 16 < -7) begin
         exp_v = {3'b010, 32'h0};                              // R7
      end else begin
         r    = m - (64'sd1 <<< k);
         frac = (r * (64'sd1 <<< 27)) / (64'sd1 <<< k);        // R3
         exp_v = {3'b000, s, 4'(k - 16 + 7), 27'(frac)};       // R1 R2
      end
   endtask

   task automatic report(input logic [34:0] got, input logic [34:0] exp_v,
                         input string req);
      vectors++;
      if (got !== exp_v) begin
         fails++;
         $display("FAIL %s: got flags=%b word=%h, expected flags=%b word=%h",
                  req, got[34:32], got[31:0], exp_v[34:32], exp_v[31:0]);
      end
   endtask

   task automatic check_bit(input logic got, input logic exp_b, input string req);
      vectors++;
      if (got !== exp_b) begin
         fails++;
         $display("FAIL %s: got %b, expected %b", req, got, exp_b);
      end
   endtask

   // Offer one input, check the result one cycle later (R9)
   task automatic apply(input logic [31:0] x, input string req);
      logic [34:0] e;
      ref_model(x, e);
      @(negedge clk);
      in_valid  = 1'b1;
      in_data   = x;
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      if (!out_valid) begin
         check_bit(out_valid, 1'b1, "R9");
      end else begin
         report({out_ovf, out_unf, out_zero, out_word}, e, req);
      end
   endtask

   function automatic string req_of(input logic [31:0] x);
      if (x == 0) return "R5";
      if (x[31]) return "R4 R1";
      return "R2 R3";
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      check_bit(out_valid, 1'b0, "R9 reset out_valid");
      check_bit(in_ready, 1'b1, "R9 reset in_ready");
      rst_n = 1'b1;
      @(negedge clk);

      apply(32'h0059_2000, "R8");
      check_bit(out_word == 32'h6B24_0000, 1'b1, "R8 literal");
      apply(32'h0000_0000, "R5");
      apply(32'h8000_0000, "R4 R6");
      apply(32'hFFFF_FFFF, "R4 R7");
      apply(32'hFFA6_E000, "R4 R1");
      // range boundaries: leading one at 8/9 and 24/25
      apply(32'h0000_0100, "R7");
      apply(32'h0000_0200, "R2");
      apply(32'h01FF_FFFF, "R3");
      apply(32'h0200_0000, "R6");
      apply(32'hFE00_0000, "R6 R4");

      // Sweep every leading-one position, both signs, several tails
      for (int p = 0; p < 31; p++) begin
         for (int pat = 0; pat < 4; pat++) begin
            logic [31:0] v;
            logic [31:0] lo;
            lo = (32'h1 << p) - 32'h1;
            case (pat)
               0: v = 32'h1 << p;
               1: v = (32'h1 << p) | lo;
               2: v = (32'h1 << p) | (lo & 32'h5A5A_5A5A);
               default: v = (32'h1 << p) | (lo & 32'hC3A1_96E5);
            endcase
            apply(v, req_of(v));
            apply(-v, req_of(-v));
         end
      end

      // Backpressure: hold result A, offer B, release later (R10)
      begin
         logic [34:0] ea, eb;
         ref_model(32'h0059_2000, ea);
         ref_model(32'hFFF0_8000, eb);
         @(negedge clk);
         out_ready = 1'b0;
         in_valid  = 1'b1;
         in_data   = 32'h0059_2000;
         @(negedge clk);
         in_data = 32'hFFF0_8000;
         for (int c = 0; c < 3; c++) begin
            check_bit(in_ready, 1'b0, "R10 in_ready stalled");
            report({out_ovf, out_unf, out_zero, out_word}, ea, "R10 hold");
            @(negedge clk);
         end
         out_ready = 1'b1;
         @(negedge clk);
         in_valid = 1'b0;
         check_bit(out_valid, 1'b1, "R10 refill valid");
         report({out_ovf, out_unf, out_zero, out_word}, eb, "R10 refill");
         @(negedge clk);
         check_bit(out_valid, 1'b0, "R9 drain");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule